// File: doc/BRIEF.md
# Mask-Directed Bit Gather/Scatter Unit

This unit splits a 32-bit word into two groups of bits, as chosen by a run-time mask. In gather mode it takes the bits that sit under mask ones and packs them at the most-significant end of the result. It takes the bits that sit under mask zeros and packs them at the least-significant end. Each group keeps its bits in their original relative order. No bit is lost, so the result is a full partition of the input word. Scatter mode is the exact inverse. It takes a word packed in that layout, plus the same mask, and moves every bit back to its original position. Because a gather keeps order, one gather can pull out several fields at once, as long as those fields already sit in the order wanted.

An operation begins when a start pulse arrives while the unit is idle. On that edge the unit captures the operand, the mask and the mode. It then works through the mask one position per cycle, from bit 0 upward. Once no mask ones are left above the current position, it fills in the remaining bits in a single step. The unit raises a one-cycle done pulse when the result is ready, and the result then stays stable until the next done. The latency depends only on the position of the highest mask one and never exceeds 32 cycles.

Top module: `bit_partition_unit`

## Requirements
- R1: Gather (mode_i = 0). Let k be the number of ones in the mask. Result bits [31:32-k] hold the source bits at mask-one positions, with the lowest such position at bit 32-k. Result bits [31-k:0] hold the source bits at mask-zero positions, with the lowest such position at bit 0. Example: source 0x000000AA with mask 0x00000025 gives 0x80000013.
- R2: Scatter (mode_i = 1) with a mask of k ones reverses R1. The n-th mask-one position, counted from bit 0, receives operand bit 32-k+n. The n-th mask-zero position receives operand bit n.
- R3: For any x and m, scatter(gather(x,m),m) equals x and gather(scatter(x,m),m) equals x.
- R4: An all-zeros mask and an all-ones mask both return the operand unchanged, in either mode.
- R5: The operand, mask and mode are sampled only on the clock edge at which start_i is accepted. Later changes to these inputs do not affect the running operation.
- R6: done_o is high during the cycle that follows the (h+1)-th rising edge after the accepting edge. Here h is the index of the highest mask one, and h = 0 for an all-zeros mask. The latency therefore lies between 1 and 32 cycles.
- R7: busy_o is high from the accepting edge until the edge that raises done_o. done_o lasts exactly one cycle and is never high together with busy_o.
- R8: A start_i pulse while busy_o is high is ignored. It does not change the result or the timing of the running operation, and it produces no extra done pulse.
- R9: While reset is held, busy_o, done_o and result_o are all 0.
- R10: result_o changes only on the edge that raises done_o, and it holds its value until the next done.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, accepted only when the unit is idle |
| mode_i | input | 1 | Operation select: 0 for gather, 1 for scatter |
| data_i | input | 32 | Operand word |
| mask_i | input | 32 | Partition mask |
| busy_o | output | 1 | An operation is in progress |
| done_o | output | 1 | One-cycle pulse marking a valid result |
| result_o | output | 32 | Last completed result |

## Verification
Each operation's done pulse is due at a fixed point: h+1 rising edges after the accepting edge, where h is the highest mask-one index. The bench drives inputs on falling edges and counts rising edges from the accepting edge. At each falling edge it samples done_o and busy_o, so it can compare the measured latency exactly against h+1. The result is read on the falling edge where done_o is first seen high. On the next falling edge the bench confirms that done_o has dropped. For the tests on ignored inputs, the bench changes the inputs or pulses start_i partway through an operation. It then checks that the result, the latency and the count of done pulses all match an undisturbed run, and that result_o stays unchanged for many cycles afterwards.

// File: rtl/bgs_pkg.sv
package bgs_pkg;
  typedef enum logic {
    OP_GATHER  = 1'b0,
    OP_SCATTER = 1'b1
  } bgs_op_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } bgs_st_e;
endpackage

// File: rtl/bgs_popcnt.sv
module bgs_popcnt #(
  parameter int W  = 32,
  parameter int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  vec_i,
  output logic [CW-1:0] cnt_o
);
  // running sum chain
  logic [CW-1:0] part [W+1];

  assign part[0] = '0;
  for (genvar g = 0; g < W; g++) begin : g_acc
    assign part[g+1] = part[g] + CW'(vec_i[g]);
  end

  assign cnt_o = part[W];
endmodule

// File: rtl/bgs_route.sv
module bgs_route
  import bgs_pkg::*;
#(
  parameter int W  = 32,
  parameter int CW = $clog2(W + 1)
) (
  input  bgs_op_e       op_i,
  input  logic [W-1:0]  word_i,
  input  logic [W-1:0]  acc_i,
  input  logic          sel_i,
  input  logic [CW-1:0] k_i,
  input  logic [CW-1:0] ones_i,
  input  logic [CW-1:0] zeros_i,
  input  logic [CW-1:0] pos_i,
  output logic [W-1:0]  acc_o,
  output logic [W-1:0]  fin_o,
  output logic [CW-1:0] ones_o,
  output logic [CW-1:0] zeros_o
);
  logic [CW-1:0] grp_idx, rd_idx, wr_idx, pos_nx;
  logic [W-1:0]  rd_hot, wr_hot, tail;
  logic          bit_v;

  // packed-side index: selected group sits above W-k
  assign grp_idx = sel_i ? (CW'(W) - k_i + ones_i) : zeros_i;
  // gather reads natural position and writes packed; scatter swaps them
  assign rd_idx  = (op_i == OP_GATHER) ? pos_i : grp_idx;
  assign wr_idx  = (op_i == OP_GATHER) ? grp_idx : pos_i;

  assign rd_hot  = W'(1) << rd_idx;
  assign wr_hot  = W'(1) << wr_idx;
  assign bit_v   = |(word_i & rd_hot);
  assign acc_o   = bit_v ? (acc_i | wr_hot) : acc_i;

  assign ones_o  = ones_i + CW'(sel_i);
  assign zeros_o = zeros_i + CW'(!sel_i);
  assign pos_nx  = pos_i + CW'(1);

  // all bits above pos are unselected: move them as one contiguous run
  assign tail  = (op_i == OP_GATHER) ? ((word_i >> pos_nx) << zeros_o)
                                     : ((word_i >> zeros_o) << pos_nx);
  assign fin_o = acc_o | tail;
endmodule

// File: rtl/bgs_ctrl.sv
module bgs_ctrl
  import bgs_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic last_i,
  output logic load_o,
  output logic step_o,
  output logic busy_o,
  output logic done_o
);
  bgs_st_e st_q;
  logic    done_q;

  assign load_o = start_i && (st_q == ST_IDLE);
  assign step_o = (st_q == ST_RUN);
  assign busy_o = step_o;
  assign done_o = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      done_q <= 1'b0;
    end else begin
      done_q <= step_o && last_i;
      if (load_o)                st_q <= ST_RUN;
      else if (step_o && last_i) st_q <= ST_IDLE;
    end
  end
endmodule

// File: rtl/bit_partition_unit.sv
module bit_partition_unit
  import bgs_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic         mode_i,
  input  logic [W-1:0] data_i,
  input  logic [W-1:0] mask_i,
  output logic         busy_o,
  output logic         done_o,
  output logic [W-1:0] result_o
);
  localparam int CW = $clog2(W + 1);

  bgs_op_e       op_q;
  logic [W-1:0]  word_q, msk_q, acc_q, res_q;
  logic [CW-1:0] k_q, ones_q, zeros_q, pos_q, k_in;
  logic [W-1:0]  acc_nx, fin;
  logic [CW-1:0] ones_nx, zeros_nx;
  logic          load, step, last;

  // no mask ones left above the current position
  assign last = (msk_q[W-1:1] == '0);

  bgs_popcnt #(.W(W), .CW(CW)) u_popcnt (
    .vec_i (mask_i),
    .cnt_o (k_in)
  );

  bgs_ctrl u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .last_i  (last),
    .load_o  (load),
    .step_o  (step),
    .busy_o  (busy_o),
    .done_o  (done_o)
  );

  bgs_route #(.W(W), .CW(CW)) u_route (
    .op_i    (op_q),
    .word_i  (word_q),
    .acc_i   (acc_q),
    .sel_i   (msk_q[0]),
    .k_i     (k_q),
    .ones_i  (ones_q),
    .zeros_i (zeros_q),
    .pos_i   (pos_q),
    .acc_o   (acc_nx),
    .fin_o   (fin),
    .ones_o  (ones_nx),
    .zeros_o (zeros_nx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q    <= OP_GATHER;
      word_q  <= '0;
      msk_q   <= '0;
      acc_q   <= '0;
      k_q     <= '0;
      ones_q  <= '0;
      zeros_q <= '0;
      pos_q   <= '0;
      res_q   <= '0;
    end else if (load) begin
      op_q    <= bgs_op_e'(mode_i);
      word_q  <= data_i;
      msk_q   <= mask_i;
      acc_q   <= '0;
      k_q     <= k_in;
      ones_q  <= '0;
      zeros_q <= '0;
      pos_q   <= '0;
    end else if (step) begin
      msk_q   <= msk_q >> 1;
      acc_q   <= acc_nx;
      ones_q  <= ones_nx;
      zeros_q <= zeros_nx;
      pos_q   <= pos_q + CW'(1);
      if (last) res_q <= fin;
    end
  end

  assign result_o = res_q;
endmodule

// File: rtl/bgs_checker.sv
module bgs_checker #(
  parameter int W = 32
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         start_i,
  input logic         busy_o,
  input logic         done_o,
  input logic [W-1:0] result_o
);
  localparam int RCW = $clog2(W + 1) + 1;
  logic [RCW-1:0] run_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     run_cnt <= '0;
    else if (busy_o) run_cnt <= run_cnt + RCW'(1);
    else             run_cnt <= '0;
  end

  assert_latency_bound_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (run_cnt < RCW'(W)));

  assert_done_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_done_not_busy_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  assert_start_to_busy_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o);

  assert_done_after_busy_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(busy_o));

  assert_result_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(result_o));

  always_comb begin
    if (!rst_ni) begin
      assert_reset_idle_R9: assert (!done_o || !busy_o);
    end
  end
endmodule

bind bit_partition_unit bgs_checker #(.W(W)) u_bgs_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .start_i  (start_i),
  .busy_o   (busy_o),
  .done_o   (done_o),
  .result_o (result_o)
);

// File: tb/bit_partition_unit_tb_top.sv
`timescale 1ns/1ps
module bit_partition_unit_tb_top;
  localparam int W = 32;
  localparam int TMO = 100000;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         start_i = 1'b0;
  logic         mode_i = 1'b0;
  logic [W-1:0] data_i = '0;
  logic [W-1:0] mask_i = '0;
  logic         busy_o, done_o;
  logic [W-1:0] result_o;

  int n_chk = 0;
  int n_err = 0;

  always #10 clk_i = ~clk_i;

  bit_partition_unit #(.W(W)) dut_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .mode_i   (mode_i),
    .data_i   (data_i),
    .mask_i   (mask_i),
    .busy_o   (busy_o),
    .done_o   (done_o),
    .result_o (result_o)
  );

  function automatic logic [W-1:0] gather_ref(input logic [W-1:0] x, input logic [W-1:0] m);
    int k = $countones(m);
    int o = 0;
    int z = 0;
    logic [W-1:0] r = '0;
    for (int i = 0; i < W; i++) begin
      if (m[i]) begin r[W-k+o] = x[i]; o++; end
      else      begin r[z] = x[i]; z++; end
    end
    return r;
  endfunction

  function automatic logic [W-1:0] scatter_ref(input logic [W-1:0] x, input logic [W-1:0] m);
    int k = $countones(m);
    int o = 0;
    int z = 0;
    logic [W-1:0] r = '0;
    for (int i = 0; i < W; i++) begin
      if (m[i]) begin r[i] = x[W-k+o]; o++; end
      else      begin r[i] = x[z]; z++; end
    end
    return r;
  endfunction

  function automatic int exp_lat(input logic [W-1:0] m);
    int h = 0;
    for (int i = 0; i < W; i++) if (m[i]) h = i;
    return h + 1;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // scramble: change inputs after acceptance; poke: extra start mid-run
  task automatic run_op(input logic md, input logic [W-1:0] d, input logic [W-1:0] m,
                        input bit scramble, input bit poke,
                        output logic [W-1:0] r, output int lat);
    bit busy_bad = 0;
    @(negedge clk_i);
    start_i = 1'b1; mode_i = md; data_i = d; mask_i = m;
    @(posedge clk_i);
    @(negedge clk_i);
    start_i = 1'b0;
    if (scramble) begin mode_i = ~md; data_i = ~d; mask_i = ~m; end
    chk(busy_o === 1'b1, "R7 busy after accept", W'(busy_o), W'(1));
    lat = 0;
    while (!done_o && lat < 40) begin
      @(posedge clk_i);
      lat++;
      @(negedge clk_i);
      if (poke) begin
        if (lat == 3) begin start_i = 1'b1; mode_i = ~md; data_i = ~d; mask_i = 32'h1; end
        if (lat == 4) start_i = 1'b0;
      end
      if (!done_o && !busy_o) busy_bad = 1;
    end
    r = result_o;
    chk(!busy_bad, "R7 busy held until done", W'(busy_bad), '0);
    chk(done_o && !busy_o, "R7 done without busy", {busy_o, done_o}, W'(1));
    chk(lat == exp_lat(m), "R6 latency", W'(lat), W'(exp_lat(m)));
    @(posedge clk_i);
    @(negedge clk_i);
    chk(done_o === 1'b0, "R7 done one cycle", W'(done_o), '0);
    chk(result_o === r, "R10 result held", result_o, r);
  endtask

  task automatic t_reset();
    chk(busy_o === 1'b0 && done_o === 1'b0, "R9 flags in reset", {busy_o, done_o}, '0);
    chk(result_o === '0, "R9 result in reset", result_o, '0);
  endtask

  task automatic t_example();
    logic [W-1:0] r; int lat;
    run_op(1'b0, 32'h0000_00AA, 32'h0000_0025, 0, 0, r, lat);
    chk(r === 32'h8000_0013, "R1 example gather", r, 32'h8000_0013);
    run_op(1'b1, 32'h8000_0013, 32'h0000_0025, 0, 0, r, lat);
    chk(r === 32'h0000_00AA, "R2 example scatter", r, 32'h0000_00AA);
  endtask

  task automatic t_fields();
    logic [W-1:0] r; int lat;
    // two fields: bits 31:28 and 7:4 land together at the top
    run_op(1'b0, 32'hA123_45B6, 32'hF000_00F0, 0, 0, r, lat);
    chk(r === gather_ref(32'hA123_45B6, 32'hF000_00F0), "R1 multi field",
        r, gather_ref(32'hA123_45B6, 32'hF000_00F0));
    chk(r[31:24] === 8'hAB, "R1 fields in order", W'(r[31:24]), W'(8'hAB));
    run_op(1'b1, 32'hC0FF_EE11, 32'h0F0F_3300, 0, 0, r, lat);
    chk(r === scatter_ref(32'hC0FF_EE11, 32'h0F0F_3300), "R2 scatter pattern",
        r, scatter_ref(32'hC0FF_EE11, 32'h0F0F_3300));
  endtask

  task automatic t_edges();
    logic [W-1:0] r; int lat;
    for (int md = 0; md < 2; md++) begin
      run_op(md[0], 32'hDEAD_BEEF, '0, 0, 0, r, lat);
      chk(r === 32'hDEAD_BEEF, "R4 zero mask", r, 32'hDEAD_BEEF);
      run_op(md[0], 32'h1357_9BDF, '1, 0, 0, r, lat);
      chk(r === 32'h1357_9BDF, "R4 ones mask", r, 32'h1357_9BDF);
    end
  endtask

  task automatic t_roundtrip();
    logic [W-1:0] g, s, x, m; int lat;
    for (int n = 0; n < 24; n++) begin
      x = $urandom;
      m = (n % 3 == 0) ? ($urandom & $urandom) : $urandom;
      run_op(1'b0, x, m, 0, 0, g, lat);
      chk(g === gather_ref(x, m), "R1 random gather", g, gather_ref(x, m));
      run_op(1'b1, g, m, 0, 0, s, lat);
      chk(s === x, "R3 scatter of gather", s, x);
      run_op(1'b1, x, m, 0, 0, s, lat);
      run_op(1'b0, s, m, 0, 0, g, lat);
      chk(g === x, "R3 gather of scatter", g, x);
    end
  endtask

  task automatic t_capture();
    logic [W-1:0] r; int lat;
    run_op(1'b0, 32'h5A5A_0FF0, 32'h00F0_0C03, 1, 0, r, lat);
    chk(r === gather_ref(32'h5A5A_0FF0, 32'h00F0_0C03), "R5 inputs sampled on accept",
        r, gather_ref(32'h5A5A_0FF0, 32'h00F0_0C03));
  endtask

  task automatic t_start_busy();
    logic [W-1:0] r; int lat; int extra = 0;
    run_op(1'b1, 32'h2468_ACE1, 32'h8000_0001, 0, 1, r, lat);
    chk(r === scatter_ref(32'h2468_ACE1, 32'h8000_0001), "R8 result with start while busy",
        r, scatter_ref(32'h2468_ACE1, 32'h8000_0001));
    chk(lat == 32, "R8 timing with start while busy", W'(lat), W'(32));
    for (int c = 0; c < 40; c++) begin
      @(posedge clk_i);
      @(negedge clk_i);
      if (done_o || busy_o) extra++;
    end
    chk(extra == 0, "R8 no extra operation", W'(extra), '0);
    chk(result_o === r, "R10 result held while idle", result_o, r);
  endtask

  initial begin
    repeat (TMO) @(posedge clk_i);
    n_chk++;
    n_err++;
    $display("FAIL watchdog expired after %0d cycles", TMO);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_example();
    t_fields();
    t_edges();
    t_capture();
    t_start_busy();
    t_roundtrip();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule